// File: doc/BRIEF.md
# Bidirectional Mailbox FIFO Pair

The block connects two bus ports, one on the host side and one on the management-controller side, through two independent byte queues that run in opposite directions. Each side sees the same small register window. A write to the data address on a side pushes a byte toward the other side. A read of that same address pops a byte that the other side sent. Each queue holds `DEPTH` bytes, 64 by default. A side can discard everything it has queued but not yet delivered by setting bit 0 of its control address. The block brings the empty and full flags of both queues out as ports, so that separate status logic can use them.

Every queue is modelled as an occupancy state machine with three states:
- `OCC_EMPTY`
- `OCC_PARTIAL`
- `OCC_FULL`

Its transitions are:
- **fill**: EMPTY to PARTIAL on an accepted push.
- **top-up**: PARTIAL to FULL when a lone push brings the count to `DEPTH`.
- **drain**: PARTIAL to EMPTY when a lone pop takes the last byte.
- **release**: FULL to PARTIAL on an accepted pop.
- **flush**: any state to EMPTY.

Every bus port runs a two-state machine:
- **accept**: `PORT_IDLE` goes to `PORT_ACK` when `cyc` and `stb` are both high. The read, push, pop or flush takes effect on that edge.
- **retire**: `PORT_ACK` returns to `PORT_IDLE` unconditionally. `ack` is high during `PORT_ACK`.

Register window, in words on `*_adr`:
- Address 0 is the data address.
- Address 1 is the control address.
- All other addresses are an empty stub.

Top module: `mbx_mailbox`

## Requirements
- R1: Each direction holds up to DEPTH (default 64) bytes and delivers them in the order they were written.
- R2: An accepted write to address 0 on one side pushes `dat_w` into the queue that only the opposite side reads. A read on the opposite side that is accepted one cycle after the write returns that byte.
- R3: An accepted read of address 0 while the inbound queue is empty returns 0x00. It leaves that queue empty.
- R4: A write to address 0 while the outbound queue is full is dropped. The full flag stays set, and the stored bytes read back unchanged.
- R5: An accepted write to address 1 with bit 0 set empties that side's outbound queue on the accept edge. Only bytes written afterwards are delivered.
- R6: Address 1 always reads 0x00, so the flush bit self-clears. A write to address 1 with bit 0 clear has no effect. Addresses 2 and 3 read 0x00, and writes to them change nothing.
- R7: An access accepted while `ack` is low gets `ack` high in the next cycle, for exactly one cycle. Read data is valid in that cycle.
- R8: A push and a pop on the same queue in the same cycle, when the queue is neither empty nor full, leave its occupancy unchanged.
- R9: After reset both queues are empty. The empty and full flags of a queue are never both high, and they reflect its occupancy one cycle after the accept edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_cyc | input | 1 | Host bus cycle valid |
| host_stb | input | 1 | Host bus strobe |
| host_we | input | 1 | Host write enable |
| host_adr | input | ADDR_W | Host word address |
| host_dat_w | input | DATA_W | Host write data |
| host_dat_r | output | DATA_W | Host read data |
| host_ack | output | 1 | Host acknowledge |
| mgmt_cyc | input | 1 | Management bus cycle valid |
| mgmt_stb | input | 1 | Management bus strobe |
| mgmt_we | input | 1 | Management write enable |
| mgmt_adr | input | ADDR_W | Management word address |
| mgmt_dat_w | input | DATA_W | Management write data |
| mgmt_dat_r | output | DATA_W | Management read data |
| mgmt_ack | output | 1 | Management acknowledge |
| h2m_empty | output | 1 | Host-to-management queue empty |
| h2m_full | output | 1 | Host-to-management queue full |
| m2h_empty | output | 1 | Management-to-host queue empty |
| m2h_full | output | 1 | Management-to-host queue full |

## Verification
The assertions rely on each master following the bus handshake. A master keeps `stb` high until it sees `ack`, and it counts a request as accepted only when `cyc` and `stb` are high while `ack` is low. The bench drives each request for exactly one accept edge and drops `stb` in the acknowledge cycle. It starts a new access only after the port has returned to idle, which keeps every request inside that assumption. It lines up concurrent pushes and pops on the two sides with a fork, so the same-cycle case is covered without breaking the handshake.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    typedef enum logic [1:0] {
        OCC_EMPTY   = 2'd0,
        OCC_PARTIAL = 2'd1,
        OCC_FULL    = 2'd2
    } occ_state_t;

    typedef enum logic {
        PORT_IDLE = 1'b0,
        PORT_ACK  = 1'b1
    } port_state_t;

    localparam int REG_DATA  = 0;
    localparam int REG_CTRL  = 1;
    localparam int FLUSH_BIT = 0;

endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo
    import mbx_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int DEPTH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    input  logic             flush,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full
);

    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
    localparam logic [AW-1:0]    LAST_C  = AW'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
    logic [CNT_W-1:0] count_q, count_d;
    occ_state_t       state_q, state_d;
    logic             push_ok, pop_ok;

    assign push_ok = push && (state_q != OCC_FULL);
    assign pop_ok  = pop  && (state_q != OCC_EMPTY);

    // Occupancy transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OCC_EMPTY: begin
                if (push_ok)
                    state_d = (DEPTH == 1) ? OCC_FULL : OCC_PARTIAL;
            end
            OCC_PARTIAL: begin
                if (push_ok && !pop_ok && (count_q == DEPTH_C - 1'b1))
                    state_d = OCC_FULL;
                else if (pop_ok && !push_ok && (count_q == CNT_W'(1)))
                    state_d = OCC_EMPTY;
            end
            OCC_FULL: begin
                if (pop_ok)
                    state_d = (DEPTH == 1) ? OCC_EMPTY : OCC_PARTIAL;
            end
            default: state_d = OCC_EMPTY;
        endcase
        if (flush)
            state_d = OCC_EMPTY;
    end

    always_comb begin
        count_d = count_q;
        if (flush)
            count_d = '0;
        else if (push_ok && !pop_ok)
            count_d = count_q + 1'b1;
        else if (pop_ok && !push_ok)
            count_d = count_q - 1'b1;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= OCC_EMPTY;
            count_q  <= '0;
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
        end else begin
            state_q <= state_d;
            count_q <= count_d;
            if (flush) begin
                wr_ptr_q <= '0;
                rd_ptr_q <= '0;
            end else begin
                if (push_ok)
                    wr_ptr_q <= (wr_ptr_q == LAST_C) ? '0 : wr_ptr_q + 1'b1;
                if (pop_ok)
                    rd_ptr_q <= (rd_ptr_q == LAST_C) ? '0 : rd_ptr_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok && !flush)
            mem[wr_ptr_q] <= push_data;
    end

    // Outputs
    always_comb begin
        head  = mem[rd_ptr_q];
        empty = (state_q == OCC_EMPTY);
        full  = (state_q == OCC_FULL);
    end

endmodule

// File: rtl/mbx_bus_port.sv
module mbx_bus_port
    import mbx_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc,
    input  logic              stb,
    input  logic              we,
    input  logic [ADDR_W-1:0] adr,
    input  logic [DATA_W-1:0] dat_w,
    output logic [DATA_W-1:0] dat_r,
    output logic              ack,
    output logic              push,
    output logic [DATA_W-1:0] push_data,
    output logic              pop,
    output logic              flush,
    input  logic [DATA_W-1:0] in_head,
    input  logic              in_empty
);

    port_state_t       state_q, state_d;
    logic              accept, hit_data, hit_ctrl;
    logic [DATA_W-1:0] rdata_q;

    assign hit_data = (adr == ADDR_W'(REG_DATA));
    assign hit_ctrl = (adr == ADDR_W'(REG_CTRL));
    assign accept   = (state_q == PORT_IDLE) && cyc && stb;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PORT_IDLE: if (cyc && stb) state_d = PORT_ACK;
            PORT_ACK:  state_d = PORT_IDLE;
            default:   state_d = PORT_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= PORT_IDLE;
        else
            state_q <= state_d;
    end

    // Registered read data
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (accept && !we)
            rdata_q <= (hit_data && !in_empty) ? in_head : '0;
    end

    // Outputs
    always_comb begin
        ack       = (state_q == PORT_ACK);
        dat_r     = rdata_q;
        push      = accept && we && hit_data;
        push_data = dat_w;
        pop       = accept && !we && hit_data;
        flush     = accept && we && hit_ctrl && dat_w[FLUSH_BIT];
    end

endmodule

// File: rtl/mbx_mailbox.sv
module mbx_mailbox
    import mbx_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 8,
    parameter int DEPTH  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_cyc,
    input  logic              host_stb,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_adr,
    input  logic [DATA_W-1:0] host_dat_w,
    output logic [DATA_W-1:0] host_dat_r,
    output logic              host_ack,
    input  logic              mgmt_cyc,
    input  logic              mgmt_stb,
    input  logic              mgmt_we,
    input  logic [ADDR_W-1:0] mgmt_adr,
    input  logic [DATA_W-1:0] mgmt_dat_w,
    output logic [DATA_W-1:0] mgmt_dat_r,
    output logic              mgmt_ack,
    output logic              h2m_empty,
    output logic              h2m_full,
    output logic              m2h_empty,
    output logic              m2h_full
);

    logic              h_push, h_pop, h_flush;
    logic              m_push, m_pop, m_flush;
    logic [DATA_W-1:0] h_push_data, m_push_data;
    logic [DATA_W-1:0] h2m_head, m2h_head;

    mbx_bus_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_host_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc       (host_cyc),
        .stb       (host_stb),
        .we        (host_we),
        .adr       (host_adr),
        .dat_w     (host_dat_w),
        .dat_r     (host_dat_r),
        .ack       (host_ack),
        .push      (h_push),
        .push_data (h_push_data),
        .pop       (h_pop),
        .flush     (h_flush),
        .in_head   (m2h_head),
        .in_empty  (m2h_empty)
    );

    mbx_bus_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mgmt_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc       (mgmt_cyc),
        .stb       (mgmt_stb),
        .we        (mgmt_we),
        .adr       (mgmt_adr),
        .dat_w     (mgmt_dat_w),
        .dat_r     (mgmt_dat_r),
        .ack       (mgmt_ack),
        .push      (m_push),
        .push_data (m_push_data),
        .pop       (m_pop),
        .flush     (m_flush),
        .in_head   (h2m_head),
        .in_empty  (h2m_empty)
    );

    // Host pushes, management pops
    mbx_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_h2m_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (h_push),
        .push_data (h_push_data),
        .pop       (m_pop),
        .flush     (h_flush),
        .head      (h2m_head),
        .empty     (h2m_empty),
        .full      (h2m_full)
    );

    // Management pushes, host pops
    mbx_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_m2h_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (m_push),
        .push_data (m_push_data),
        .pop       (h_pop),
        .flush     (m_flush),
        .head      (m2h_head),
        .empty     (m2h_empty),
        .full      (m2h_full)
    );

endmodule

// File: rtl/mbx_mailbox_chk.sv
module mbx_mailbox_chk
    import mbx_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_cyc,
    input logic              host_stb,
    input logic              host_we,
    input logic [ADDR_W-1:0] host_adr,
    input logic [DATA_W-1:0] host_dat_w,
    input logic [DATA_W-1:0] host_dat_r,
    input logic              host_ack,
    input logic              mgmt_cyc,
    input logic              mgmt_stb,
    input logic              mgmt_we,
    input logic [ADDR_W-1:0] mgmt_adr,
    input logic [DATA_W-1:0] mgmt_dat_w,
    input logic [DATA_W-1:0] mgmt_dat_r,
    input logic              mgmt_ack,
    input logic              h2m_empty,
    input logic              h2m_full,
    input logic              m2h_empty,
    input logic              m2h_full
);

    logic h_acc, m_acc;
    assign h_acc = host_cyc && host_stb && !host_ack;
    assign m_acc = mgmt_cyc && mgmt_stb && !mgmt_ack;

    assert_host_ack_next_R7: assert property (@(posedge clk) disable iff (!rst_n)
        h_acc |=> host_ack);
    assert_mgmt_ack_next_R7: assert property (@(posedge clk) disable iff (!rst_n)
        m_acc |=> mgmt_ack);
    assert_host_ack_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |=> !host_ack);
    assert_mgmt_ack_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mgmt_ack |=> !mgmt_ack);

    assert_h2m_flags_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(h2m_empty && h2m_full));
    assert_m2h_flags_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(m2h_empty && m2h_full));

    assert_host_push_visible_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (h_acc && host_we && host_adr == ADDR_W'(REG_DATA)) |=> !h2m_empty);
    assert_mgmt_push_visible_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (m_acc && mgmt_we && mgmt_adr == ADDR_W'(REG_DATA)) |=> !m2h_empty);

    assert_mgmt_empty_read_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (m_acc && !mgmt_we && mgmt_adr == ADDR_W'(REG_DATA) && h2m_empty)
        |=> (mgmt_dat_r == '0));
    assert_host_empty_read_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (h_acc && !host_we && host_adr == ADDR_W'(REG_DATA) && m2h_empty)
        |=> (host_dat_r == '0));

    assert_h2m_full_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (h2m_full && h_acc && host_we && host_adr == ADDR_W'(REG_DATA)
         && !(m_acc && !mgmt_we && mgmt_adr == ADDR_W'(REG_DATA))) |=> h2m_full);

    assert_host_flush_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (h_acc && host_we && host_adr == ADDR_W'(REG_CTRL) && host_dat_w[FLUSH_BIT])
        |=> (h2m_empty && !h2m_full));
    assert_mgmt_flush_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (m_acc && mgmt_we && mgmt_adr == ADDR_W'(REG_CTRL) && mgmt_dat_w[FLUSH_BIT])
        |=> (m2h_empty && !m2h_full));

    assert_host_ctrl_reads_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (h_acc && !host_we && host_adr != ADDR_W'(REG_DATA)) |=> (host_dat_r == '0));
    assert_mgmt_ctrl_reads_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (m_acc && !mgmt_we && mgmt_adr != ADDR_W'(REG_DATA)) |=> (mgmt_dat_r == '0));

endmodule

bind mbx_mailbox mbx_mailbox_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mbx_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_cyc   (host_cyc),
    .host_stb   (host_stb),
    .host_we    (host_we),
    .host_adr   (host_adr),
    .host_dat_w (host_dat_w),
    .host_dat_r (host_dat_r),
    .host_ack   (host_ack),
    .mgmt_cyc   (mgmt_cyc),
    .mgmt_stb   (mgmt_stb),
    .mgmt_we    (mgmt_we),
    .mgmt_adr   (mgmt_adr),
    .mgmt_dat_w (mgmt_dat_w),
    .mgmt_dat_r (mgmt_dat_r),
    .mgmt_ack   (mgmt_ack),
    .h2m_empty  (h2m_empty),
    .h2m_full   (h2m_full),
    .m2h_empty  (m2h_empty),
    .m2h_full   (m2h_full)
);

// File: tb/test_mbx_mailbox.sv
`timescale 1ns/1ps
module test_mbx_mailbox;

    localparam int DEPTH = 64;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       host_cyc, host_stb, host_we;
    logic [1:0] host_adr;
    logic [7:0] host_dat_w, host_dat_r;
    logic       host_ack;
    logic       mgmt_cyc, mgmt_stb, mgmt_we;
    logic [1:0] mgmt_adr;
    logic [7:0] mgmt_dat_w, mgmt_dat_r;
    logic       mgmt_ack;
    logic       h2m_empty, h2m_full, m2h_empty, m2h_full;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    mbx_mailbox #(.ADDR_W(2), .DATA_W(8), .DEPTH(DEPTH)) i_mbx_mailbox (
        .clk(clk), .rst_n(rst_n),
        .host_cyc(host_cyc), .host_stb(host_stb), .host_we(host_we),
        .host_adr(host_adr), .host_dat_w(host_dat_w), .host_dat_r(host_dat_r),
        .host_ack(host_ack),
        .mgmt_cyc(mgmt_cyc), .mgmt_stb(mgmt_stb), .mgmt_we(mgmt_we),
        .mgmt_adr(mgmt_adr), .mgmt_dat_w(mgmt_dat_w), .mgmt_dat_r(mgmt_dat_r),
        .mgmt_ack(mgmt_ack),
        .h2m_empty(h2m_empty), .h2m_full(h2m_full),
        .m2h_empty(m2h_empty), .m2h_full(m2h_full)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // side 0 = host, side 1 = management
    task automatic acc(input int side, input bit wr, input int adr, input int wd,
                       output int rd);
        @(negedge clk);
        if (side == 0) begin
            host_cyc = 1'b1; host_stb = 1'b1; host_we = wr;
            host_adr = adr[1:0]; host_dat_w = wd[7:0];
        end else begin
            mgmt_cyc = 1'b1; mgmt_stb = 1'b1; mgmt_we = wr;
            mgmt_adr = adr[1:0]; mgmt_dat_w = wd[7:0];
        end
        @(posedge clk);
        @(negedge clk);
        if (side == 0) begin
            chk("R7 host ack", int'(host_ack), 1);
            rd = int'(host_dat_r);
            host_cyc = 1'b0; host_stb = 1'b0; host_we = 1'b0;
        end else begin
            chk("R7 mgmt ack", int'(mgmt_ack), 1);
            rd = int'(mgmt_dat_r);
            mgmt_cyc = 1'b0; mgmt_stb = 1'b0; mgmt_we = 1'b0;
        end
    endtask

    task automatic wr(input int side, input int adr, input int d);
        int dummy;
        acc(side, 1'b1, adr, d, dummy);
    endtask

    task automatic rdchk(input int side, input int adr, input int exp, input string req);
        int v;
        acc(side, 1'b0, adr, 0, v);
        chk(req, v, exp);
    endtask

    // flags of the queue that side s writes into
    function automatic int out_empty(input int s);
        return (s == 0) ? int'(h2m_empty) : int'(m2h_empty);
    endfunction
    function automatic int out_full(input int s);
        return (s == 0) ? int'(h2m_full) : int'(m2h_full);
    endfunction

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        host_cyc = 0; host_stb = 0; host_we = 0; host_adr = 0; host_dat_w = 0;
        mgmt_cyc = 0; mgmt_stb = 0; mgmt_we = 0; mgmt_adr = 0; mgmt_dat_w = 0;
        rst_n = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R9 reset state
        chk("R9 h2m_empty reset", int'(h2m_empty), 1);
        chk("R9 h2m_full reset",  int'(h2m_full), 0);
        chk("R9 m2h_empty reset", int'(m2h_empty), 1);
        chk("R9 m2h_full reset",  int'(m2h_full), 0);
        chk("R7 host ack idle",   int'(host_ack), 0);
        chk("R7 mgmt ack idle",   int'(mgmt_ack), 0);

        // R3 empty reads on both sides
        rdchk(0, 0, 0, "R3 host empty read");
        rdchk(1, 0, 0, "R3 mgmt empty read");
        chk("R3 m2h stays empty", int'(m2h_empty), 1);
        chk("R3 h2m stays empty", int'(h2m_empty), 1);

        // R1/R4/R9 fill sweep in both directions, including overflow
        for (int s = 0; s < 2; s++) begin
            for (int i = 0; i < DEPTH; i++) begin
                wr(s, 0, (i * 37 + s * 5 + 1) & 8'hFF);
                chk("R9 empty flag during fill", out_empty(s), 0);
                chk("R9 full flag during fill", out_full(s), (i == DEPTH - 1) ? 1 : 0);
            end
            wr(s, 0, 8'hEE);
            chk("R4 full stays after overflow write", out_full(s), 1);
            for (int i = 0; i < DEPTH; i++)
                rdchk(1 - s, 0, (i * 37 + s * 5 + 1) & 8'hFF, "R1 in-order readback");
            chk("R4 overflow byte dropped, empty after drain", out_empty(s), 1);
            rdchk(1 - s, 0, 0, "R3 read after drain");
        end

        // R2 cross-side read accepted one cycle after the write
        for (int s = 0; s < 2; s++) begin
            fork
                wr(s, 0, 8'h12 + s);
                begin
                    @(negedge clk);
                    rdchk(1 - s, 0, 8'h12 + s, "R2 next-cycle cross read");
                end
            join
            chk("R2 queue empty again", out_empty(s), 1);
        end

        // R6 control read, bit0 clear, stub addresses
        for (int s = 0; s < 2; s++) begin
            wr(s, 0, 8'hA1);
            wr(s, 0, 8'hA2);
            wr(s, 1, 8'hFE);
            wr(s, 2, 8'h55);
            wr(s, 3, 8'hFF);
            rdchk(s, 1, 0, "R6 control reads zero");
            rdchk(s, 2, 0, "R6 stub address reads zero");
            rdchk(s, 3, 0, "R6 stub address reads zero");
            rdchk(1 - s, 0, 8'hA1, "R6 no flush on bit0 clear");
            rdchk(1 - s, 0, 8'hA2, "R6 stub write no effect");
            rdchk(1 - s, 0, 0,     "R6 nothing extra queued");
        end

        // R5 flush at several fill levels
        for (int s = 0; s < 2; s++) begin
            for (int lvl = 0; lvl <= DEPTH; lvl += 21) begin
                for (int i = 0; i < lvl; i++) wr(s, 0, 8'h5A ^ s);
                wr(s, 1, 8'h01);
                chk("R5 empty after flush", out_empty(s), 1);
                chk("R5 not full after flush", out_full(s), 0);
                rdchk(s, 1, 0, "R5 flush bit self-clears");
                wr(s, 0, 8'h98 - s * 32);
                rdchk(1 - s, 0, 8'h98 - s * 32, "R5 post-flush byte");
                rdchk(1 - s, 0, 0, "R5 only post-flush data");
            end
            for (int i = 0; i < DEPTH; i++) wr(s, 0, i);
            wr(s, 1, 8'hFF);
            chk("R5 flush from full", out_empty(s), 1);
        end

        // R8 simultaneous push and pop with occupancy DEPTH-1
        for (int s = 0; s < 2; s++) begin
            for (int i = 0; i < DEPTH - 1; i++) wr(s, 0, i);
            fork
                wr(s, 0, 8'h80);
                rdchk(1 - s, 0, 0, "R8 concurrent pop head");
            join
            chk("R8 not full after push+pop", out_full(s), 0);
            wr(s, 0, 8'h81);
            chk("R8 full after one more push", out_full(s), 1);
            for (int i = 1; i < DEPTH - 1; i++) rdchk(1 - s, 0, i, "R8 order kept");
            rdchk(1 - s, 0, 8'h80, "R8 concurrent byte kept");
            rdchk(1 - s, 0, 8'h81, "R8 last byte");
            chk("R8 empty at end", out_empty(s), 1);
        end

        // R7 ack drops after its single cycle
        @(negedge clk);
        chk("R7 host ack single cycle", int'(host_ack), 0);
        chk("R7 mgmt ack single cycle", int'(mgmt_ack), 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule